// File: doc/BRIEF.md
# DSP Interrupt Control Register

This block is one 16-bit register that a DSP core reads and writes. It gathers three interrupt requests for that core. Source 2 is a set strobe from the host processor, source 1 is an ADC conversion-done pulse, and source 0 is a timer pulse. Each request is latched as a pending flag. The register also holds a mask bit for each source, one global enable and a 3-bit priority field. The priority field is stored here and is used only by the core.

Software cannot write the pending flags directly. It removes them by writing 1 to separate clear-strobe bits in the same word. Another bit of the word drives an interrupt line back to the host. That bit can be written but always reads back as zero. Each DSP interrupt output is the registered AND of its pending flag, its mask bit and the global enable.

Top module: `dsp_irq_ctrl`

## Requirements
- R1: Bits 15, 14 and 13 of the read word are the pending flags for sources 2, 1 and 0. Writing any value to these bit positions leaves the flags unchanged.
- R2: A high `host_set` in a cycle sets pending flag 2 at that clock edge. A high `adc_done` sets flag 1 the same way, and a high `tmr_evt` sets flag 0.
- R3: Bits 12, 11 and 10 are mask bits for sources 2, 1 and 0. A write stores them and a read returns them. A 1 lets the source through and a 0 blocks it.
- R4: A write stores bit 9 as the level of `host_irq`, so 1 sets the line and 0 clears it. Bit 9 of the read word is always 0.
- R5: Bit 8 is the global enable. A write stores it and a read returns it. A 1 enables all sources.
- R6: Bits 7 to 5 form a 3-bit priority field. A write stores it and a read returns it.
- R7: Writing 1 to bit 4, 3 or 2 clears pending flag 2, 1 or 0 respectively. Writing 0 to these bits has no effect, and they read as 0.
- R8: Bits 1 and 0 read as 0, and writes to them have no effect on any state or output.
- R9: `dsp_irq[i]` is registered. One cycle after a given state of pending flag i, mask bit i and the global enable, it equals their AND.
- R10: If a set event and a clear strobe reach the same flag in the same cycle, the flag ends up set.
- R11: After reset, the read word, `dsp_irq` and `host_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | DSP write strobe for the register |
| wr_data | input | 16 | DSP write data |
| rd_data | output | 16 | Current register read value |
| host_set | input | 1 | Host strobe that sets pending flag 2 |
| adc_done | input | 1 | ADC conversion-done pulse that sets pending flag 1 |
| tmr_evt | input | 1 | Timer pulse that sets pending flag 0 |
| dsp_irq | output | 3 | Gated interrupt requests to the DSP core |
| host_irq | output | 1 | Interrupt line to the host processor |

## Verification
A source event and a DSP write that carries the matching clear strobe can occur in the same cycle. The bench provokes this for all three sources. It drives `host_set`, `adc_done` or `tmr_evt` in the same cycle as a write that has the matching strobe bit at 1, and also while other flags are being cleared. The result is judged on the next read word, where the flag must still be set. It is also judged one cycle later on `dsp_irq`, while the neighbouring flags that were only cleared must read as 0.

// File: rtl/dsp_irq_ctrl.sv
module dsp_irq_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic        host_set,
  input  logic        adc_done,
  input  logic        tmr_evt,
  output logic [2:0]  dsp_irq,
  output logic        host_irq
);

  localparam int PEND_LSB = 13;
  localparam int MASK_LSB = 10;
  localparam int HOST_BIT = 9;
  localparam int GEN_BIT  = 8;
  localparam int PRI_LSB  = 5;
  localparam int CLR_LSB  = 2;

  logic [2:0] pend_q, mask_q, pri_q;
  logic       gen_q, host_q;
  logic [2:0] set_v, clr_v;

  assign set_v = {host_set, adc_done, tmr_evt};
  assign clr_v = wr_en ? wr_data[CLR_LSB +: 3] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      pri_q  <= '0;
      gen_q  <= 1'b0;
      host_q <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr_v) | set_v;
      if (wr_en) begin
        mask_q <= wr_data[MASK_LSB +: 3];
        pri_q  <= wr_data[PRI_LSB +: 3];
        gen_q  <= wr_data[GEN_BIT];
        host_q <= wr_data[HOST_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dsp_irq <= '0;
    else        dsp_irq <= pend_q & mask_q & {3{gen_q}};
  end

  assign rd_data  = {pend_q, mask_q, 1'b0, gen_q, pri_q, 5'b00000};
  assign host_irq = host_q;

endmodule

module dsp_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        host_set,
  input logic        adc_done,
  input logic        tmr_evt,
  input logic [2:0]  dsp_irq,
  input logic        host_irq
);

  p_host_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_set |=> rd_data[15]);
  p_adc_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_done |=> rd_data[14]);
  p_tmr_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_evt |=> rd_data[13]);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[3] && !adc_done) |=> !rd_data[14]);
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[2] && tmr_evt) |=> rd_data[13]);
  p_pend_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_set && !(wr_en && wr_data[4])) |=> $stable(rd_data[15]));
  p_host_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> host_irq == $past(wr_data[9]));
  p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data[12:5]) && $stable(host_irq));
  p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> dsp_irq == ($past(rd_data[15:13]) & $past(rd_data[12:10]) & {3{$past(rd_data[8])}}));

endmodule

bind dsp_irq_ctrl dsp_irq_ctrl_chk u_chk (.*);

// File: tb/test_dsp_irq_ctrl.sv
module test_dsp_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        host_set = 1'b0, adc_done = 1'b0, tmr_evt = 1'b0;
  logic [2:0]  dsp_irq;
  logic        host_irq;

  dsp_irq_ctrl i_dsp_irq_ctrl (.*);

  always #5 clk = ~clk;

  typedef struct {
    int          due;
    bit          is_irq;
    logic [16:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [2:0] m_pend = '0, m_mask = '0, m_pri = '0;
  logic       m_gen = 1'b0, m_host = 1'b0;

  task automatic step(input bit wr, input logic [15:0] d,
                      input bit hs, input bit ad, input bit tm, input string tag);
    logic [2:0] clr;
    item_t it;
    @(negedge clk);
    wr_en = wr; wr_data = d; host_set = hs; adc_done = ad; tmr_evt = tm;
    clr = wr ? d[4:2] : 3'b000;
    m_pend = (m_pend & ~clr) | {hs, ad, tm};
    if (wr) begin
      m_mask = d[12:10]; m_pri = d[7:5]; m_gen = d[8]; m_host = d[9];
    end
    it.due = cyc + 1; it.is_irq = 1'b0; it.tag = tag;
    it.exp = {m_host, m_pend, m_mask, 1'b0, m_gen, m_pri, 5'b0};
    q.push_back(it);
    it.due = cyc + 2; it.is_irq = 1'b1;
    it.exp = {14'b0, m_pend & m_mask & {3{m_gen}}};
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #3;
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      logic [16:0] act;
      it = q.pop_front();
      act = it.is_irq ? {14'b0, dsp_irq} : {host_irq, rd_data};
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s %s: actual %h expected %h", it.tag,
                 it.is_irq ? "dsp_irq" : "host_irq,rd_data", act, it.exp);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #22;
    n_chk++;
    if ({host_irq, dsp_irq, rd_data} !== '0) begin
      n_bad++;
      $display("FAIL R11 reset: actual %h expected 0", {host_irq, dsp_irq, rd_data});
    end
    rst_n = 1'b1;
    step(0, 16'h0, 0, 0, 0, "R11 idle");
    // sources set flags while masked off
    step(0, 16'h0, 1, 0, 0, "R2 host");
    step(0, 16'h0, 0, 1, 0, "R2 adc");
    step(0, 16'h0, 0, 0, 1, "R2 tmr");
    step(0, 16'h0, 0, 0, 0, "R9 gated off");
    // enable masks and global enable, priority, host line; also writes to pend/reserved bits
    step(1, 16'b000_111_1_1_101_000_11, 0, 0, 0, "R3 R5 R6 R4 R8");
    step(0, 16'h0, 0, 0, 0, "R9 all pass");
    // write pending bits to zero with no strobes: no effect
    step(1, 16'b000_111_0_1_101_000_00, 0, 0, 0, "R1 R4 clear host");
    // clear flag 1 only
    step(1, 16'b111_111_0_1_010_010_00, 0, 0, 0, "R7 clear1");
    step(0, 16'h0, 0, 0, 0, "R7 hold");
    // mask source 2 off
    step(1, 16'b000_011_0_1_010_000_00, 0, 0, 0, "R3 mask2");
    // global disable
    step(1, 16'b000_111_0_0_010_000_00, 0, 0, 0, "R5 disable");
    step(1, 16'b000_111_0_1_111_000_00, 0, 0, 0, "R5 R6 enable");
    // set wins over clear, each source
    step(1, 16'b000_111_0_1_111_111_00, 1, 0, 0, "R10 host");
    step(1, 16'b000_111_0_1_111_111_00, 0, 1, 0, "R10 adc");
    step(1, 16'b000_111_0_1_111_111_00, 0, 0, 1, "R10 tmr");
    step(1, 16'b000_111_0_1_111_111_00, 1, 1, 1, "R10 all");
    step(1, 16'b000_111_1_1_111_111_00, 0, 0, 0, "R7 clear all");
    step(0, 16'h0, 1, 0, 1, "R2 two");
    step(1, 16'b000_101_0_1_001_000_11, 0, 1, 0, "R8 R9 mixed");
    for (int i = 0; i < 40; i++)
      step(i[0], 16'((i * 16'h2F3B) ^ 16'h9A51), i % 3 == 0, i % 5 == 1, i % 7 == 2, "R9 sweep");
    step(0, 16'h0, 0, 0, 0, "R1 tail");
    step(0, 16'h0, 0, 0, 0, "R9 tail");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule